// File: doc/BRIEF.md
# Multi-Mode GF(2^8) Polynomial Multiplier

This block forms the product of two polynomials whose coefficients are symbols of GF(2^8). The multiplicand, of up to `A_LEN` coefficients, is captured into an internal register when the block is cleared. The multiplier, of `B_LEN` coefficients, is applied in one of three ways. It can arrive serially, highest degree first. It can arrive serially, lowest degree first. It can be presented all at once on a wide bus. The product coefficients up to degree `KEEP_DEG` build up in an output register bank. They stay there for a downstream key-equation stage to read.

In the two serial modes, each valid coefficient updates the whole bank in one cycle, and the product is complete after `B_LEN` coefficients. In the parallel mode a single strobe computes the whole truncated product combinationally and stores it in one cycle. A one-cycle done pulse marks the moment the bank holds the finished result. Terms above `KEEP_DEG` are dropped, so the result is the product reduced modulo x^(KEEP_DEG+1).

Top module: `gfpm_mult_top`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, every product coefficient is zero and `done_o` is low.
- R2: A cycle with `clear_i` high zeroes every product coefficient, captures `a_i` as the multiplicand, restarts the coefficient count and keeps `done_o` low. When `coef_valid_i` is high in the same cycle, clear wins and that coefficient is dropped.
- R3: Mode 1 (`mode_i`=1) takes coefficients highest degree first. On each valid cycle the bank shifts up one degree and adds the coefficient times the multiplicand. After `B_LEN` valid cycles the bank holds the product.
- R4: Mode 3 (`mode_i`=3) takes coefficients lowest degree first. On each valid cycle the bank adds the coefficient times the multiplicand, and the multiplicand is shifted up one degree. After `B_LEN` valid cycles the bank holds the product.
- R5: Mode 2 (`mode_i`=2) reads all `B_LEN` coefficients from `coef_par_i` in the one cycle `coef_valid_i` is high, and stores the full product at that clock edge.
- R6: `done_o` is high for exactly one cycle: the cycle after the final coefficient was absorbed (the `B_LEN`-th serial coefficient, or the parallel strobe).
- R7: Once a product is complete, further valid cycles leave the bank unchanged until the next clear. A cycle without valid or clear also leaves it unchanged.
- R8: Mode 0 ignores `coef_valid_i`: the bank and the coefficient count are left unchanged.
- R9: Product terms of degree above `KEEP_DEG` (default 16) are discarded. The defaults `A_LEN`=8 and `B_LEN`=12 allow degree 18.
- R10: Arithmetic is in GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1. Addition is XOR. Coefficient k of every vector port occupies bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 idle, 1 serial high-first, 2 parallel, 3 serial low-first |
| clear_i | input | 1 | Zero the product, load the multiplicand, restart the count |
| a_i | input | A_LEN*8 | Multiplicand coefficients, captured on clear |
| coef_i | input | 8 | Serial multiplier coefficient |
| coef_valid_i | input | 1 | Coefficient strobe (serial and parallel modes) |
| coef_par_i | input | B_LEN*8 | Parallel multiplier coefficients |
| prod_o | output | (KEEP_DEG+1)*8 | Product coefficients, degree 0 in the low byte |
| done_o | output | 1 | One-cycle pulse when the product is complete |

## Verification
Clear and a valid coefficient can land in the same cycle. The bench forces this collision in mode 1 with a non-zero coefficient. It then expects an all-zero bank and no done pulse. A fresh run of `B_LEN` coefficients must then give exactly their product, which shows the dropped coefficient did not advance the count. The final coefficient and its done pulse are followed straight away by more valid strobes. Those strobes are judged by checking that the stored product and `done_o` do not change.

// File: rtl/gfpm_pkg.sv
package gfpm_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] PRIM = 9'h11D;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_SER_HI = 2'd1,
    MODE_PAR    = 2'd2,
    MODE_SER_LO = 2'd3
  } mode_e;

  function automatic sym_t gf_mul(sym_t x, sym_t y);
    sym_t acc;
    sym_t t;
    acc = '0;
    t   = x;
    for (int i = 0; i < SYM_W; i++) begin
      if (y[i]) acc ^= t;
      t = t[SYM_W-1] ? ((t << 1) ^ PRIM[SYM_W-1:0]) : (t << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/gfpm_ser_lane.sv
module gfpm_ser_lane
  import gfpm_pkg::*;
(
  input  sym_t coef_i,
  input  sym_t mult_i,
  input  sym_t base_i,
  output sym_t nxt_o
);
  assign nxt_o = base_i ^ gf_mul(coef_i, mult_i);
endmodule

// File: rtl/gfpm_par_mult.sv
module gfpm_par_mult
  import gfpm_pkg::*;
#(
  parameter int A_LEN = 8,
  parameter int B_LEN = 12,
  parameter int N_OUT = 17
) (
  input  sym_t [A_LEN-1:0] a_i,
  input  sym_t [B_LEN-1:0] b_i,
  output sym_t [N_OUT-1:0] p_o
);
  always_comb begin
    p_o = '0;
    for (int k = 0; k < N_OUT; k++) begin
      for (int i = 0; i < A_LEN; i++) begin
        if (k - i >= 0 && k - i < B_LEN) p_o[k] ^= gf_mul(a_i[i], b_i[k-i]);
      end
    end
  end
endmodule

// File: rtl/gfpm_ctrl.sv
module gfpm_ctrl
  import gfpm_pkg::*;
#(
  parameter int B_LEN = 12
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  clear_i,
  input  logic  valid_i,
  output logic  take_o,
  output logic  done_o
);
  localparam int CNT_W = $clog2(B_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(B_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(B_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign take_o = valid_i && !clear_i && (mode_i != MODE_IDLE) && (cnt_q != CNT_END);
  assign last   = (mode_i == MODE_PAR) || (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= take_o && last;
      if (clear_i)     cnt_q <= '0;
      else if (take_o) cnt_q <= last ? CNT_END : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gfpm_mult_top.sv
module gfpm_mult_top
  import gfpm_pkg::*;
#(
  parameter int A_LEN    = 8,
  parameter int B_LEN    = 12,
  parameter int KEEP_DEG = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  mode_i,
  input  logic                        clear_i,
  input  logic [A_LEN*SYM_W-1:0]      a_i,
  input  logic [SYM_W-1:0]            coef_i,
  input  logic                        coef_valid_i,
  input  logic [B_LEN*SYM_W-1:0]      coef_par_i,
  output logic [(KEEP_DEG+1)*SYM_W-1:0] prod_o,
  output logic                        done_o
);
  localparam int N_OUT = KEEP_DEG + 1;

  mode_e mode;
  logic  take;
  sym_t [N_OUT-1:0] prod_q, a_sh_q, a_ext, ser_nxt, par_p;
  sym_t [B_LEN-1:0] b_par;

  assign mode  = mode_e'(mode_i);
  assign a_ext = {{((N_OUT-A_LEN)*SYM_W){1'b0}}, a_i};
  assign b_par = coef_par_i;

  gfpm_ctrl #(.B_LEN(B_LEN)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .clear_i(clear_i),
    .valid_i(coef_valid_i),
    .take_o (take),
    .done_o (done_o)
  );

  gfpm_par_mult #(.A_LEN(A_LEN), .B_LEN(B_LEN), .N_OUT(N_OUT)) u_par (
    .a_i(a_sh_q[A_LEN-1:0]),
    .b_i(b_par),
    .p_o(par_p)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane
    sym_t base;
    if (k == 0) begin : g_lo
      assign base = (mode == MODE_SER_HI) ? '0 : prod_q[0];
    end else begin : g_up
      assign base = (mode == MODE_SER_HI) ? prod_q[k-1] : prod_q[k];
    end
    gfpm_ser_lane u_lane (
      .coef_i(coef_i),
      .mult_i(a_sh_q[k]),
      .base_i(base),
      .nxt_o (ser_nxt[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      a_sh_q <= '0;
    end else if (clear_i) begin
      prod_q <= '0;
      a_sh_q <= a_ext;
    end else if (take) begin
      prod_q <= (mode == MODE_PAR) ? par_p : ser_nxt;
      // low-first: multiplicand moves up one degree per absorbed coefficient
      if (mode == MODE_SER_LO) a_sh_q <= {a_sh_q[N_OUT-2:0], sym_t'(0)};
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/gfpm_mult_chk.sv
module gfpm_mult_chk #(
  parameter int P_W = 136
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [1:0]     mode_i,
  input logic           clear_i,
  input logic           coef_valid_i,
  input logic [P_W-1:0] prod_o,
  input logic           done_o
);
  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (prod_o == '0) && !done_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(coef_valid_i) && !$past(clear_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!coef_valid_i && !clear_i) |=> $stable(prod_o) && !done_o);

  p_idle_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !clear_i) |=> $stable(prod_o) && !done_o);
endmodule

bind gfpm_mult_top gfpm_mult_chk #(.P_W((KEEP_DEG+1)*8)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .clear_i     (clear_i),
  .coef_valid_i(coef_valid_i),
  .prod_o      (prod_o),
  .done_o      (done_o)
);

// File: tb/gfpm_mult_top_test.sv
`timescale 1ns/1ps
module gfpm_mult_top_test;
  localparam int A_LEN = 8;
  localparam int B_LEN = 12;
  localparam int KEEP  = 16;
  localparam int PW    = (KEEP+1)*8;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_i = 0;
  logic clear_i = 0, valid_i = 0;
  logic [A_LEN*8-1:0] a_i = '0;
  logic [7:0] coef_i = '0;
  logic [B_LEN*8-1:0] par_i = '0;
  logic [PW-1:0] prod_o;
  logic done_o;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;
  logic [PW-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  gfpm_mult_top #(.A_LEN(A_LEN), .B_LEN(B_LEN), .KEEP_DEG(KEEP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .clear_i(clear_i),
    .a_i(a_i), .coef_i(coef_i), .coef_valid_i(valid_i), .coef_par_i(par_i),
    .prod_o(prod_o), .done_o(done_o));

  // R10 reference: xtime-based field multiply
  function automatic logic [7:0] xt(logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1D : 8'h00);
  endfunction
  function automatic logic [7:0] rmul(logic [7:0] x, logic [7:0] y);
    logic [7:0] r = 0;
    for (int i = 7; i >= 0; i--) r = xt(r) ^ (y[i] ? x : 8'h00);
    return r;
  endfunction
  function automatic logic [PW-1:0] ref_prod(logic [A_LEN*8-1:0] a, logic [B_LEN*8-1:0] b);
    logic [PW-1:0] p = '0;
    for (int i = 0; i < A_LEN; i++)
      for (int j = 0; j < B_LEN; j++)
        if (i + j <= KEEP) p[(i+j)*8 +: 8] ^= rmul(a[i*8 +: 8], b[j*8 +: 8]);
    return p;
  endfunction

  task automatic check(bit ok, string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: scoreboard pop on every done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) check(0, "R6 unexpected done", prod_o, '0);
      else begin
        automatic logic [PW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(prod_o == e, t, prod_o, e);
      end
    end
  end

  task automatic do_clear(logic [A_LEN*8-1:0] a);
    clear_i = 1; a_i = a; valid_i = 0;
    @(negedge clk);
    clear_i = 0;
  endtask

  task automatic run_serial(logic [1:0] m, logic [A_LEN*8-1:0] a, logic [B_LEN*8-1:0] b,
                            bit clr, string tag);
    if (clr) do_clear(a);
    mode_i = m;
    exp_q.push_back(ref_prod(a, b)); tag_q.push_back(tag);
    for (int j = 0; j < B_LEN; j++) begin
      coef_i = (m == 2'd1) ? b[(B_LEN-1-j)*8 +: 8] : b[j*8 +: 8];
      valid_i = 1;
      @(negedge clk);
    end
    valid_i = 0;
    @(negedge clk);
    check(!done_o, {tag, " R6 pulse width"}, PW'(done_o), '0);
  endtask

  task automatic run_par(logic [A_LEN*8-1:0] a, logic [B_LEN*8-1:0] b, string tag);
    do_clear(a);
    mode_i = 2'd2; par_i = b;
    exp_q.push_back(ref_prod(a, b)); tag_q.push_back(tag);
    valid_i = 1;
    @(negedge clk);
    valid_i = 0;
    @(negedge clk);
    check(!done_o, {tag, " R6 pulse width"}, PW'(done_o), '0);
  endtask

  function automatic logic [A_LEN*8-1:0] rnd_a();
    logic [A_LEN*8-1:0] v;
    for (int i = 0; i < A_LEN; i++) v[i*8 +: 8] = 8'($urandom);
    return v;
  endfunction
  function automatic logic [B_LEN*8-1:0] rnd_b();
    logic [B_LEN*8-1:0] v;
    for (int i = 0; i < B_LEN; i++) v[i*8 +: 8] = 8'($urandom);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    logic [A_LEN*8-1:0] a, a_top;
    logic [B_LEN*8-1:0] b, b_top;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(prod_o == '0 && !done_o, "R1 reset state", prod_o, '0);

    for (int r = 0; r < 4; r++) begin
      run_serial(2'd1, rnd_a(), rnd_b(), 1, "R3 R9 R10 serial hi-first");
      run_serial(2'd3, rnd_a(), rnd_b(), 1, "R4 R9 R10 serial lo-first");
      run_par(rnd_a(), rnd_b(), "R5 R9 R10 parallel");
    end

    // R9 corners: top term x^18 dropped; x^16 kept
    a_top = '0; a_top[(A_LEN-1)*8 +: 8] = 8'h01;
    b_top = '0; b_top[(B_LEN-1)*8 +: 8] = 8'h01;
    run_serial(2'd1, a_top, b_top, 1, "R9 drop top hi-first");
    run_serial(2'd3, a_top, b_top, 1, "R9 drop top lo-first");
    run_par(a_top, b_top, "R9 drop top parallel");
    a_top[(A_LEN-1)*8 +: 8] = 8'h03;
    b_top = '0; b_top[9*8 +: 8] = 8'h05;
    run_par(a_top, b_top, "R9 keep degree 16");
    run_serial(2'd3, a_top, b_top, 1, "R9 keep degree 16 lo-first");

    // R7: extra strobes after completion are ignored
    a = rnd_a(); b = rnd_b();
    run_serial(2'd1, a, b, 1, "R3 before extra strobes");
    valid_i = 1; coef_i = 8'h55;
    repeat (3) @(negedge clk);
    valid_i = 0;
    check(prod_o == ref_prod(a, b) && !done_o, "R7 ignore after done", prod_o, ref_prod(a, b));
    mode_i = 2'd2; par_i = rnd_b(); valid_i = 1;
    @(negedge clk);
    valid_i = 0;
    check(prod_o == ref_prod(a, b) && !done_o, "R7 ignore parallel after done", prod_o, ref_prod(a, b));

    // R2: clear collides with a valid coefficient
    a = rnd_a(); b = rnd_b();
    do_clear(a);
    mode_i = 2'd1; clear_i = 1; valid_i = 1; coef_i = 8'hFF;
    @(negedge clk);
    clear_i = 0; valid_i = 0;
    check(prod_o == '0 && !done_o, "R2 clear wins over valid", prod_o, '0);
    run_serial(2'd1, a, b, 0, "R2 count restarted after collision");

    // R8: idle mode ignores strobes, count untouched
    a = rnd_a(); b = rnd_b();
    do_clear(a);
    mode_i = 2'd0; valid_i = 1; coef_i = 8'hA7;
    repeat (4) @(negedge clk);
    valid_i = 0;
    check(prod_o == '0 && !done_o, "R8 idle mode ignored", prod_o, '0);
    run_serial(2'd3, a, b, 0, "R8 count untouched by idle");

    // R2: clear zeroes a finished product
    do_clear(rnd_a());
    check(prod_o == '0 && !done_o, "R2 clear zeroes bank", prod_o, '0);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results delivered", PW'(exp_q.size()), '0);
    finish_run();
  end
endmodule